// File: doc/BRIEF.md
# Keyed Option Word Controller

This block keeps a non-volatile option word behind two key-sequence locks that must be opened in order. Software uses a plain register bus with an address, a write enable, write data and combinational read data. It first writes a two-word key pair to the main key register, which opens the control lock. It then writes a second, different pair to the option key register, which opens the option lock. With both locks open, it loads a new value into the staged option register and sets the start bit. A fixed-latency busy phase stands in for the cell programming time. When that phase ends, the staged value becomes the stored word.

At the first clock after each reset, the block decodes the stored word into a boot-target output. The stored word decides whether the target follows a boot pin sampled at that moment or a boot bit held in the word itself. The stored word keeps its value through reset, so a committed change only alters the boot target after the next reset.

Top module: `optguard_ctrl`

## Requirements
- R1: Straight after reset, control (offset 0x14) reads 0xC0000000, status (offset 0x10) reads 0x00000000, and the option register (offset 0x20) reads the stored word, which is 0xFFEFFCAA from power-up.
- R2: Control bit 31 (main lock) clears only after 0x45670123 and then 0xCDEF89AB are written to offset 0x08, in that order. Control then reads 0x40000000.
- R3: Control bit 30 (option lock) clears only after 0x08192A3B and then 0x4C5D6E7F are written to offset 0x0C while the main lock is already clear. Control then reads 0x00000000.
- R4: Each lock is frozen shut until the next reset by any of these writes to its key register: a wrong value, the second key before the first, or an option key written while the main lock is set.
- R5: Writes to the option register, and writes of control bit 17 (start), have no effect while either lock is set or a commit is busy.
- R6: An accepted start sets status bit 16 (busy) for exactly 16 cycles, counted from the clock edge that takes the write. Control bit 17 reads 1 for the same cycles. When busy drops, the staged word becomes the stored word and bit 17 reads 0.
- R7: Writing 1 to control bit 31 sets the main lock again. Writing 1 to control bit 30 sets the option lock again.
- R8: The boot pin is sampled only on the first clock after reset is released. The boot target then holds until the next reset. A word committed in between does not change the target.
- R9: Boot decode (target code 0 = flash application, 1 = system ROM, 2 = SRAM). When word bit 26 is 1, the effective boot-bar value is the inverted boot pin; when bit 26 is 0, it is word bit 27. If the effective value is 1, the target is flash. Otherwise bit 23 picks system ROM when it is 1 and SRAM when it is 0.
- R10: A committed word survives reset. After the reset, offset 0x20 reads it back and the boot decode uses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| boot_pin | input | 1 | Boot strap pin, sampled once after reset |
| boot_target | output | 2 | 0 flash application, 1 system ROM, 2 SRAM |

## Verification
The assertions check four things on every cycle. A lock opens only on the second key write. The option lock opens only while the main lock is open. The staged word stays frozen while it is locked or busy. The stored word changes only as busy falls, and the boot target does not move after it has been sampled. Other behaviours need the bench's scenarios to show them: that a frozen lock stays shut when the correct keys follow, the exact 16-cycle busy window, and that a commit changes the boot target only after a later reset, with each of the three targets reached.

// File: rtl/optguard_pkg.sv
package optguard_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_KEY    = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_OPTKEY = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_WORD   = 8'h20;

    localparam logic [DATA_W-1:0] MAIN_KEY_A = 32'h4567_0123;
    localparam logic [DATA_W-1:0] MAIN_KEY_B = 32'hCDEF_89AB;
    localparam logic [DATA_W-1:0] OPT_KEY_A  = 32'h0819_2A3B;
    localparam logic [DATA_W-1:0] OPT_KEY_B  = 32'h4C5D_6E7F;
    localparam logic [DATA_W-1:0] WORD_INIT  = 32'hFFEF_FCAA;

    localparam int BIT_MAIN_LOCK = 31;
    localparam int BIT_OPT_LOCK  = 30;
    localparam int BIT_START     = 17;
    localparam int BIT_BUSY      = 16;
    localparam int BIT_SW_SEL    = 26;
    localparam int BIT_NB0       = 27;
    localparam int BIT_NB1       = 23;

    typedef enum logic [1:0] {
        TGT_FLASH = 2'd0,
        TGT_SYSROM = 2'd1,
        TGT_SRAM = 2'd2
    } boot_tgt_e;

    typedef enum logic [1:0] {
        KS_WAIT_A,
        KS_WAIT_B,
        KS_OPEN,
        KS_FROZEN
    } key_state_e;

    function automatic boot_tgt_e decode_boot(input logic [DATA_W-1:0] word,
                                              input logic pin);
        logic nb0_eff;
        nb0_eff = word[BIT_SW_SEL] ? ~pin : word[BIT_NB0];
        if (nb0_eff)          return TGT_FLASH;
        else if (word[BIT_NB1]) return TGT_SYSROM;
        else                  return TGT_SRAM;
    endfunction
endpackage

// File: rtl/optguard_keylock.sv
module optguard_keylock
    import optguard_pkg::*;
#(
    parameter logic [DATA_W-1:0] KEY_A = '0,
    parameter logic [DATA_W-1:0] KEY_B = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    input  logic              relock,
    output logic              locked
);
    key_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= KS_WAIT_A;
        end else if (relock && state_q != KS_FROZEN) begin
            state_q <= KS_WAIT_A;
        end else if (key_wr) begin
            case (state_q)
                KS_WAIT_A: state_q <= (enable && key_data == KEY_A) ? KS_WAIT_B : KS_FROZEN;
                KS_WAIT_B: state_q <= (enable && key_data == KEY_B) ? KS_OPEN : KS_FROZEN;
                default:   state_q <= state_q;
            endcase
        end
    end

    assign locked = (state_q != KS_OPEN);

    // R2 / R3: a lock opens only on an accepted second key write
    assert_open_on_second_key_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> ($past(key_wr) && $past(key_data) == KEY_B && $past(enable)));
endmodule

// File: rtl/optguard_commit.sv
module optguard_commit
    import optguard_pkg::*;
#(
    parameter int LATENCY = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [DATA_W-1:0] staged,
    output logic              busy,
    output logic [DATA_W-1:0] stored
);
    localparam int CNT_W = $clog2(LATENCY + 1);

    logic [CNT_W-1:0]  cnt_q;
    logic              busy_q;
    logic [DATA_W-1:0] nv_q = WORD_INIT;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (launch) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == CNT_W'(LATENCY - 1)) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // stored word is non-volatile: no reset term
    always_ff @(posedge clk) begin
        if (!rst && busy_q && cnt_q == CNT_W'(LATENCY - 1)) begin
            nv_q <= staged;
        end
    end

    assign busy   = busy_q;
    assign stored = nv_q;

    // R6: the stored word only moves as a commit completes
    assert_store_on_finish_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(nv_q) |-> $fell(busy_q));
endmodule

// File: rtl/optguard_bootsel.sv
module optguard_bootsel
    import optguard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] stored,
    input  logic              boot_pin,
    output boot_tgt_e         target
);
    logic      armed_q;
    boot_tgt_e target_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q  <= 1'b0;
            target_q <= TGT_FLASH;
        end else if (!armed_q) begin
            armed_q  <= 1'b1;
            target_q <= decode_boot(stored, boot_pin);
        end
    end

    assign target = target_q;

    // R8: once sampled, the target holds until reset
    assert_target_held_R8: assert property (@(posedge clk) disable iff (rst)
        (armed_q && $past(armed_q)) |-> $stable(target_q));
endmodule

// File: rtl/optguard_ctrl.sv
module optguard_ctrl
    import optguard_pkg::*;
#(
    parameter int LATENCY = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              boot_pin,
    output logic [1:0]        boot_target
);
    logic              main_locked, opt_locked, busy, any_lock;
    logic              wr_key, wr_optkey, wr_ctrl, wr_word, launch;
    logic [DATA_W-1:0] staged_q, stored;
    boot_tgt_e         tgt;

    assign wr_key    = bus_we && bus_addr == OFS_KEY;
    assign wr_optkey = bus_we && bus_addr == OFS_OPTKEY;
    assign wr_ctrl   = bus_we && bus_addr == OFS_CTRL;
    assign wr_word   = bus_we && bus_addr == OFS_WORD;
    assign any_lock  = main_locked || opt_locked;
    assign launch    = wr_ctrl && bus_wdata[BIT_START] && !any_lock && !busy;

    optguard_keylock #(.KEY_A(MAIN_KEY_A), .KEY_B(MAIN_KEY_B)) u_main_lock (
        .clk(clk), .rst(rst), .enable(1'b1), .key_wr(wr_key), .key_data(bus_wdata),
        .relock(wr_ctrl && bus_wdata[BIT_MAIN_LOCK]), .locked(main_locked));

    optguard_keylock #(.KEY_A(OPT_KEY_A), .KEY_B(OPT_KEY_B)) u_opt_lock (
        .clk(clk), .rst(rst), .enable(!main_locked), .key_wr(wr_optkey), .key_data(bus_wdata),
        .relock(wr_ctrl && bus_wdata[BIT_OPT_LOCK]), .locked(opt_locked));

    optguard_commit #(.LATENCY(LATENCY)) u_commit (
        .clk(clk), .rst(rst), .launch(launch), .staged(staged_q),
        .busy(busy), .stored(stored));

    optguard_bootsel u_boot (
        .clk(clk), .rst(rst), .stored(stored), .boot_pin(boot_pin), .target(tgt));

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_q <= stored;
        end else if (wr_word && !any_lock && !busy) begin
            staged_q <= bus_wdata;
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_CTRL: bus_rdata = {main_locked, opt_locked, 12'b0, busy, 17'b0};
            OFS_STAT: bus_rdata = {15'b0, busy, 16'b0};
            OFS_WORD: bus_rdata = staged_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign boot_target = tgt;

    // R3: the option lock never opens while the main lock is set
    assert_opt_after_main_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(opt_locked) |-> $past(!main_locked));

    // R5: staged word frozen while locked or busy
    assert_staged_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        (any_lock || busy) |=> $stable(staged_q));

    // R5: a commit only starts from a fully unlocked state
    assert_start_needs_unlock_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(!main_locked && !opt_locked));
endmodule

// File: tb/optguard_ctrl_test.sv
module optguard_ctrl_test;
    import optguard_pkg::*;

    typedef struct {
        bit          is_boot;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        boot_pin = 1'b0;
    logic [1:0]  boot_target;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;
    item_t exp_q[$];

    always #2.5 clk = ~clk;

    optguard_ctrl uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .boot_pin(boot_pin), .boot_target(boot_target));

    function automatic void score(logic [31:0] act, logic [31:0] exp, string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endfunction

    // monitor: pops expected items and compares against the design outputs
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                score(it.is_boot ? {30'b0, boot_target} : bus_rdata, it.exp, it.tag);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_addr = a;
        exp_q.push_back('{1'b0, e, tag});
        @(negedge clk);
    endtask

    task automatic expect_boot(input logic [1:0] e, input string tag);
        @(negedge clk);
        exp_q.push_back('{1'b1, {30'b0, e}, tag});
        @(negedge clk);
    endtask

    task automatic do_reset(input logic pin);
        @(negedge clk);
        boot_pin = pin; rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic unlock_both();
        wr(OFS_KEY, MAIN_KEY_A);
        wr(OFS_KEY, MAIN_KEY_B);
        wr(OFS_OPTKEY, OPT_KEY_A);
        wr(OFS_OPTKEY, OPT_KEY_B);
    endtask

    task automatic commit_word(input logic [31:0] w);
        unlock_both();
        wr(OFS_WORD, w);
        wr(OFS_CTRL, 32'h0002_0000);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        #(5 * 150000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        int busy_n;
        // R1 reset state, R9 default word with pin low gives flash
        do_reset(1'b0);
        expect_rd(OFS_CTRL, 32'hC000_0000, "R1 control");
        expect_rd(OFS_STAT, 32'h0, "R1 status");
        expect_rd(OFS_WORD, 32'hFFEF_FCAA, "R1 option word");
        expect_boot(TGT_FLASH, "R9 pin low flash");

        // R5 locked writes ignored
        wr(OFS_WORD, 32'h0);
        wr(OFS_CTRL, 32'h0002_0000);
        expect_rd(OFS_STAT, 32'h0, "R5 start ignored locked");
        expect_rd(OFS_WORD, 32'hFFEF_FCAA, "R5 word ignored locked");

        // R9 pin high gives system ROM; R8 later pin change ignored
        do_reset(1'b1);
        expect_boot(TGT_SYSROM, "R9 pin high sysrom");
        boot_pin = 1'b0;
        repeat (3) @(negedge clk);
        expect_boot(TGT_SYSROM, "R8 pin change after sample");

        // R4 out-of-order main key freezes lock
        wr(OFS_KEY, MAIN_KEY_B);
        wr(OFS_KEY, MAIN_KEY_A);
        wr(OFS_KEY, MAIN_KEY_B);
        expect_rd(OFS_CTRL, 32'hC000_0000, "R4 main frozen");

        // R4 option key before main unlock freezes option lock
        do_reset(1'b0);
        wr(OFS_OPTKEY, OPT_KEY_A);
        wr(OFS_KEY, MAIN_KEY_A);
        wr(OFS_KEY, MAIN_KEY_B);
        expect_rd(OFS_CTRL, 32'h4000_0000, "R2 main open");
        wr(OFS_OPTKEY, OPT_KEY_A);
        wr(OFS_OPTKEY, OPT_KEY_B);
        expect_rd(OFS_CTRL, 32'h4000_0000, "R4 option frozen");

        // R4 wrong value on second word
        do_reset(1'b0);
        wr(OFS_KEY, MAIN_KEY_A);
        wr(OFS_KEY, 32'h1234_5678);
        wr(OFS_KEY, MAIN_KEY_A);
        wr(OFS_KEY, MAIN_KEY_B);
        expect_rd(OFS_CTRL, 32'hC000_0000, "R4 wrong second key");

        // R2 R3 full unlock and commit R6
        do_reset(1'b0);
        wr(OFS_KEY, MAIN_KEY_A);
        wr(OFS_KEY, MAIN_KEY_B);
        expect_rd(OFS_CTRL, 32'h4000_0000, "R2 after main pair");
        wr(OFS_OPTKEY, OPT_KEY_A);
        wr(OFS_OPTKEY, OPT_KEY_B);
        expect_rd(OFS_CTRL, 32'h0, "R3 after option pair");
        wr(OFS_WORD, 32'hF3EF_FCAA);
        expect_rd(OFS_WORD, 32'hF3EF_FCAA, "R5 staged write accepted");
        wr(OFS_CTRL, 32'h0002_0000);
        busy_n = 0;
        bus_addr = OFS_CTRL;
        #1;
        score(bus_rdata, 32'h0002_0000, "R6 start bit while busy");
        bus_addr = OFS_STAT;
        #1;
        while (bus_rdata[BIT_BUSY] && busy_n < 100) begin
            busy_n++;
            @(negedge clk);
            #1;
        end
        score(busy_n, 16, "R6 busy cycles");
        expect_rd(OFS_CTRL, 32'h0, "R6 start self-clear");
        expect_boot(TGT_FLASH, "R8 commit not applied before reset");

        // R5 write during busy ignored
        wr(OFS_CTRL, 32'h0002_0000);
        wr(OFS_WORD, 32'h1234_5678);
        repeat (20) @(negedge clk);
        expect_rd(OFS_WORD, 32'hF3EF_FCAA, "R5 word ignored busy");

        // R7 relock
        wr(OFS_CTRL, 32'h8000_0000);
        expect_rd(OFS_CTRL, 32'h8000_0000, "R7 main relocked");
        wr(OFS_CTRL, 32'h4000_0000);
        expect_rd(OFS_CTRL, 32'hC000_0000, "R7 option relocked");
        wr(OFS_WORD, 32'h0);
        expect_rd(OFS_WORD, 32'hF3EF_FCAA, "R5 word ignored relocked");

        // R10 persistence, R9 stored bit decides
        do_reset(1'b0);
        expect_boot(TGT_SYSROM, "R10 committed sysrom");
        expect_rd(OFS_WORD, 32'hF3EF_FCAA, "R10 word after reset");

        commit_word(32'hFBEF_FCAA);
        do_reset(1'b1);
        expect_boot(TGT_FLASH, "R9 stored flash ignores pin");

        commit_word(32'hF36F_FCAA);
        do_reset(1'b0);
        expect_boot(TGT_SRAM, "R9 stored sram");
        do_reset(1'b1);
        expect_boot(TGT_SRAM, "R9 stored sram pin high");

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule